// File: doc/BRIEF.md
# External Edge Event Counter

This block counts qualifying transitions on an asynchronous event line and raises an interrupt each time a programmed number of transitions has been seen. The event line first passes through a two-stage synchroniser. An edge detector then picks out rising edges, falling edges, both, or none, according to a two-bit mode field. Each qualifying edge advances a 16-bit up-counter.

The counter reads all-ones while the block is disabled. The first qualifying edge after enable loads zero, and that edge is the start of the count. When the counter takes the value held in the compare buffer, a one-cycle interrupt pulse is raised. The next qualifying edge clears the counter to zero instead of adding one, so every interval after the first is one edge longer. The host writes the compare value into a holding register. The comparator reads a buffered copy, which is refreshed while the block is disabled and on every clear-after-match.

Top module: `edge_event_counter`

## Requirements
- R1: While rst_n is low, and right after reset is released, count_q reads 16'hFFFF and irq reads 0.
- R2: While enable is 0, count_q is 16'hFFFF and irq is 0 one clock later, no edge is counted, and any pending match is dropped.
- R3: edge_sel picks the qualifying edge of event_in: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both.
- R4: The first qualifying edge after enable takes the counter from 16'hFFFF to 16'h0000. Each later qualifying edge that does not follow a match adds one.
- R5: irq is high for exactly one clock, in the same cycle that count_q first shows a value equal to the buffered compare value.
- R6: The qualifying edge that follows a match clears count_q to 16'h0000 instead of incrementing it.
- R7: With compare value D0, the first irq comes D0 qualifying edges after the count-start edge, and each later irq comes D0+1 edges after the previous one. With D0 = 0, every qualifying edge raises irq.
- R8: A cmp_wr pulse stores cmp_wdata in the holding register. The comparator buffer copies the holding register while disabled and at each clear-after-match, so a write made in mid-interval takes effect from the next interval.
- R9: A level change on event_in shows up in count_q and irq on the third rising clock edge after it is sampled, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Count enable; 0 holds the counter at all-ones |
| edge_sel | input | 2 | Qualifying edge mode (00 none, 01 rise, 10 fall, 11 both) |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 16 | Compare value to store |
| event_in | input | 1 | Asynchronous external event line |
| count_q | output | 16 | Current counter value |
| irq | output | 1 | One-cycle match interrupt |

## Verification
The assertions assume that event_in holds each level for at least two system clocks. Without that, the both-edges mode with a zero compare value could raise irq on back-to-back cycles and break the single-pulse property. The stimulus holds every event level for four clocks and changes edge_sel and cmp_wdata only between edges. Every R5 and R7 sequence therefore produces isolated edges, and each irq pulse stands alone.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/evc_edge_detect.sv
module evc_edge_detect
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       async_i,
  input  logic [1:0] mode_i,
  output logic       evt_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_n;
  logic          prev_q;
  logic          rise, fall;
  edge_mode_e    mode;

  // synchroniser chain
  always_comb begin
    sync_n = {sync_q[LAST-1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[LAST];
    end
  end

  always_comb begin
    mode = edge_mode_e'(mode_i);
    rise = sync_q[LAST] & ~prev_q;
    fall = ~sync_q[LAST] & prev_q;
    unique case (mode)
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end

  assert_none_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |-> !evt_o);
  assert_single_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && mode_i != 2'b11 && $stable(mode_i)) |=> !evt_o);
endmodule

// File: rtl/evc_cmp_buffer.sv
module evc_cmp_buffer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] hold_q, hold_n;
  logic [CNT_W-1:0] act_q, act_n;

  always_comb begin
    hold_n = hold_q;
    if (wr_i) hold_n = wdata_i;
    act_n = act_q;
    if (load_i) act_n = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i)   hold_q <= hold_n;
      if (load_i) act_q  <= act_n;
    end
  end

  assign hold_o   = hold_q;
  assign active_o = act_q;

  assert_buffer_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(active_o));
  assert_buffer_copies_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o == $past(hold_o)));
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] cmp_hold_i,
  input  logic [CNT_W-1:0] cmp_active_i,
  output logic             clear_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic             irq_q, irq_n;
  logic [CNT_W-1:0] cmp_eff;
  logic             step;

  always_comb begin
    step    = enable_i & evt_i;
    clear_o = step & pend_q;
    cmp_eff = clear_o ? cmp_hold_i : cmp_active_i;
    cnt_n   = cnt_q;
    pend_n  = pend_q;
    irq_n   = 1'b0;
    if (!enable_i) begin
      cnt_n  = ALL_ONES;
      pend_n = 1'b0;
    end else if (step) begin
      cnt_n  = pend_q ? '0 : cnt_q + ONE;
      irq_n  = (cnt_n == cmp_eff);
      pend_n = irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ALL_ONES;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  assert_off_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (count_o == ALL_ONES && !irq_o));
  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && evt_i && !pend_q) |=> (count_o == $past(count_o) + ONE));
  assert_clear_after_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && evt_i && pend_q) |=> (count_o == '0));
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_irq_has_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(enable_i && evt_i));
  assert_hold_without_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !evt_i) |=> $stable(count_o));
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       edge_sel,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             event_in,
  output logic [CNT_W-1:0] count_q,
  output logic             irq
);
  logic             evt;
  logic             clear_evt;
  logic             buf_load;
  logic [CNT_W-1:0] cmp_hold;
  logic [CNT_W-1:0] cmp_active;

  evc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (event_in),
    .mode_i  (edge_sel),
    .evt_o   (evt)
  );

  // buffer follows the holding register while idle, and again at each clear
  assign buf_load = ~enable | clear_evt;

  evc_cmp_buffer #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cmp_wr),
    .wdata_i  (cmp_wdata),
    .load_i   (buf_load),
    .hold_o   (cmp_hold),
    .active_o (cmp_active)
  );

  evc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable),
    .evt_i        (evt),
    .cmp_hold_i   (cmp_hold),
    .cmp_active_i (cmp_active),
    .clear_o      (clear_evt),
    .count_o      (count_q),
    .irq_o        (irq)
  );
endmodule

// File: tb/test_edge_event_counter.sv
module test_edge_event_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [1:0]  edge_sel;
  logic        cmp_wr;
  logic [15:0] cmp_wdata;
  logic        event_in;
  logic [15:0] count_q;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_event_counter i_edge_event_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .edge_sel(edge_sel),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .event_in(event_in),
    .count_q(count_q), .irq(irq)
  );

  // {level, expected count, expected irq}: D0 = 2, rising edges
  localparam logic [17:0] VEC [12] = '{
    {1'b1, 16'h0000, 1'b0}, {1'b0, 16'h0000, 1'b0},
    {1'b1, 16'h0001, 1'b0}, {1'b0, 16'h0001, 1'b0},
    {1'b1, 16'h0002, 1'b1}, {1'b0, 16'h0002, 1'b0},
    {1'b1, 16'h0000, 1'b0}, {1'b0, 16'h0000, 1'b0},
    {1'b1, 16'h0001, 1'b0}, {1'b0, 16'h0001, 1'b0},
    {1'b1, 16'h0002, 1'b1}, {1'b0, 16'h0002, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive a level, watch four clocks; irq pulses counted, count sampled early and late
  task automatic step(input logic lvl, output logic [15:0] cnt, output int pulses,
                      output logic [15:0] early);
    @(negedge clk);
    event_in = lvl;
    pulses = 0;
    early = 16'h0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      pulses += int'(irq);
      if (k == 2) early = count_q;
    end
    cnt = count_q;
  endtask

  task automatic write_cmp(input logic [15:0] v);
    @(negedge clk);
    cmp_wr = 1'b1;
    cmp_wdata = v;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic run(input string tag, input logic lvl, input logic [15:0] ec, input int ei);
    logic [15:0] c, e;
    int p;
    step(lvl, c, p, e);
    check({tag, " count"}, 32'(c), 32'(ec));
    check({tag, " irq"}, 32'(p), 32'(ei));
  endtask

  task automatic restart(input logic [1:0] sel);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    edge_sel = sel;
    enable = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c, e;
    int p;
    rst_n = 1'b0; enable = 1'b0; edge_sel = 2'b01;
    cmp_wr = 1'b0; cmp_wdata = '0; event_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset count", 32'(count_q), 32'hFFFF);
    check("R1 reset irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(count_q), 32'hFFFF);

    // vector table: R4 R5 R6 R7
    write_cmp(16'd2);
    restart(2'b01);
    foreach (VEC[i]) begin
      run($sformatf("R7 vec%0d", i), VEC[i][17], VEC[i][16:1], int'(VEC[i][0]));
    end

    // R2: disable returns all-ones, edges ignored
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R2 disabled count", 32'(count_q), 32'hFFFF);
    run("R2 edge while off", 1'b1, 16'hFFFF, 0);
    run("R2 edge while off b", 1'b0, 16'hFFFF, 0);

    // R3 falling mode, with R9 latency
    write_cmp(16'd5);
    restart(2'b10);
    run("R3 rise ignored in fall mode", 1'b1, 16'hFFFF, 0);
    step(1'b0, c, p, e);
    check("R9 not yet at second edge", 32'(e), 32'hFFFF);
    check("R3 fall counted", 32'(c), 32'h0);
    // R3 both
    @(negedge clk); edge_sel = 2'b11;
    run("R3 both rise", 1'b1, 16'h1, 0);
    run("R3 both fall", 1'b0, 16'h2, 0);
    // R3 none
    @(negedge clk); edge_sel = 2'b00;
    run("R3 none rise", 1'b1, 16'h2, 0);
    run("R3 none fall", 1'b0, 16'h2, 0);

    // R8 mid-interval write
    write_cmp(16'd3);
    restart(2'b01);
    run("R8 a", 1'b1, 16'h0, 0); run("R8 a0", 1'b0, 16'h0, 0);
    run("R8 b", 1'b1, 16'h1, 0); run("R8 b0", 1'b0, 16'h1, 0);
    write_cmp(16'd1);
    run("R8 old value kept", 1'b1, 16'h2, 0); run("R8 c0", 1'b0, 16'h2, 0);
    run("R8 old match", 1'b1, 16'h3, 1); run("R8 d0", 1'b0, 16'h3, 0);
    run("R6 clear", 1'b1, 16'h0, 0); run("R8 e0", 1'b0, 16'h0, 0);
    run("R8 new value used", 1'b1, 16'h1, 1); run("R8 f0", 1'b0, 16'h1, 0);

    // R7 D0 = 0: every edge
    write_cmp(16'd0);
    restart(2'b01);
    run("R7 zero first", 1'b1, 16'h0, 1); run("R7 z0", 1'b0, 16'h0, 0);
    run("R7 zero again", 1'b1, 16'h0, 1); run("R7 z1", 1'b0, 16'h0, 0);

    // R2 pending dropped on disable
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R2 pending dropped count", 32'(count_q), 32'hFFFF);
    check("R2 pending dropped irq", 32'(irq), 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule